// File: doc/BRIEF.md
# Sampled Tournament Replacement-Policy Selector

This block decides, for every set of a cache, whether that set evicts with a cost-aware replacement policy or with plain LRU. A small group of leader sets always runs the cost-aware policy in the main tag array and at the same time keeps an LRU shadow copy of its tags in an auxiliary directory. On each leader lookup the block compares the two outcomes. A single saturating score counter for the whole cache is then adjusted by the quantized cost of a miss that only one of the two policies suffered.

All other sets are followers. A follower takes whichever policy the score counter currently favours, read from the counter's most significant bit. The tag arrays, the cost measurement and the victim choice sit outside this block. It receives the set index of each lookup, the hit result of the main array, the hit result of the LRU shadow and the miss cost. It returns the policy select and a leader flag for the indexed set. The flag tells the surrounding logic which sets need a shadow entry.

Top module: `policy_duel_sel`

## Requirements
- R1: After reset the score counter holds its midpoint, 2^(CTR_W-1), so every follower set reads polSel = 1 (cost-aware).
- R2: leaderSet is 1 exactly when setIdx[LEAD_W-1:0] equals setIdx[SET_W-1 -: LEAD_W]. With the default SET_W = 10 and LEAD_W = 5 this gives 32 leader sets.
- R3: For a leader set polSel is always 1 (cost-aware), whatever the counter holds.
- R4: For a follower set polSel equals the counter's most significant bit: 1 selects cost-aware and 0 selects LRU.
- R5: A valid leader lookup in which mainHit equals auxHit (both hit or both miss) leaves the counter unchanged.
- R6: A valid leader lookup with mainHit = 1 and auxHit = 0 raises the counter by missCost on the next clock edge.
- R7: A valid leader lookup with mainHit = 0 and auxHit = 1 lowers the counter by missCost on the next clock edge.
- R8: An increase that would pass 2^CTR_W - 1 leaves the counter at 2^CTR_W - 1.
- R9: A decrease that would go below 0 leaves the counter at 0.
- R10: A lookup to a follower set, and any cycle with lookupValid = 0, leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A lookup result is presented this cycle |
| setIdx | input | SET_W | Set index of the lookup, also the set whose policy is reported |
| mainHit | input | 1 | Main array hit; for a leader this is the cost-aware outcome |
| auxHit | input | 1 | Hit in the LRU shadow directory |
| missCost | input | COST_W | Quantized cost of the miss that occurred |
| polSel | output | 1 | Policy for setIdx: 1 cost-aware, 0 LRU |
| leaderSet | output | 1 | setIdx is a sampled leader set |

## Verification
The bench builds the block with SET_W = 6, LEAD_W = 3, CTR_W = 6 and COST_W = 3: 64 sets, 8 leaders, a counter range of 0 to 63 and costs of 0 to 7. At these sizes every set index can be swept for the leader decode and for the policy select. Every pairing of hit outcomes can be applied with every cost value. A few dozen cost-7 steps are enough to pin the counter at either rail and then show, through the follower select bit, that it was clamped rather than wrapped.

// File: rtl/duel_pkg.sv
package duel_pkg;

  // Outcome of one leader lookup, seen from the cost-aware policy.
  typedef enum logic [1:0] {
    OUT_TIE      = 2'd0,
    OUT_COST_WIN = 2'd1,
    OUT_LRU_WIN  = 2'd2
  } outcome_t;

  // Strobes from control to the score datapath.
  typedef struct packed {
    logic bump;
    logic drop;
  } scoreCmd_t;

  function automatic outcome_t classify(input logic costHit, input logic lruHit);
    if (costHit && !lruHit) return OUT_COST_WIN;
    if (!costHit && lruHit) return OUT_LRU_WIN;
    return OUT_TIE;
  endfunction

endpackage

// File: rtl/duel_leader_match.sv
module duel_leader_match #(
  parameter int SET_W  = 10,
  parameter int LEAD_W = 5
) (
  input  logic [SET_W-1:0] setIdx,
  output logic             isLeader
);
  localparam int HI_LSB = SET_W - LEAD_W;

  logic [LEAD_W-1:0] bitEq;

  // Leaders are the sets whose low field mirrors their high field.
  for (genvar g = 0; g < LEAD_W; g++) begin : g_cmp
    assign bitEq[g] = (setIdx[g] == setIdx[HI_LSB + g]);
  end

  assign isLeader = &bitEq;
endmodule

// File: rtl/duel_ctrl.sv
module duel_ctrl
  import duel_pkg::*;
(
  input  logic      lookupValid,
  input  logic      isLeader,
  input  logic      mainHit,
  input  logic      auxHit,
  input  logic      scoreMsb,
  output scoreCmd_t cmd,
  output logic      polSel
);
  outcome_t outcome;

  always_comb begin
    outcome  = classify(mainHit, auxHit);
    cmd      = '0;
    if (lookupValid && isLeader) begin
      unique case (outcome)
        OUT_COST_WIN: cmd.bump = 1'b1;
        OUT_LRU_WIN:  cmd.drop = 1'b1;
        default:      ;
      endcase
    end
  end

  // Leaders stay on the cost-aware policy; followers track the score.
  assign polSel = isLeader | scoreMsb;
endmodule

// File: rtl/duel_score_dp.sv
module duel_score_dp
  import duel_pkg::*;
#(
  parameter int CTR_W  = 10,
  parameter int COST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  scoreCmd_t         cmd,
  input  logic [COST_W-1:0] amount,
  output logic [CTR_W-1:0]  score
);
  localparam int SUM_W = CTR_W + 1;
  localparam logic [CTR_W-1:0] TOP_VAL = '1;
  localparam logic [CTR_W-1:0] MID_VAL = CTR_W'(1) << (CTR_W - 1);

  logic [SUM_W-1:0] upSum;
  logic [SUM_W-1:0] dnDiff;
  logic [CTR_W-1:0] scoreNext;

  always_comb begin
    upSum     = {1'b0, score} + SUM_W'(amount);
    dnDiff    = {1'b0, score} - SUM_W'(amount);
    scoreNext = score;
    if (cmd.bump)
      scoreNext = upSum[CTR_W] ? TOP_VAL : upSum[CTR_W-1:0];
    else if (cmd.drop)
      scoreNext = dnDiff[CTR_W] ? '0 : dnDiff[CTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) score <= MID_VAL;
    else       score <= scoreNext;
  end
endmodule

// File: rtl/policy_duel_sel.sv
module policy_duel_sel
  import duel_pkg::*;
#(
  parameter int SET_W  = 10,
  parameter int LEAD_W = 5,
  parameter int CTR_W  = 10,
  parameter int COST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [SET_W-1:0]  setIdx,
  input  logic              mainHit,
  input  logic              auxHit,
  input  logic [COST_W-1:0] missCost,
  output logic              polSel,
  output logic              leaderSet
);
  scoreCmd_t        cmd;
  logic [CTR_W-1:0] ctrVal;

  duel_leader_match #(.SET_W(SET_W), .LEAD_W(LEAD_W)) u_match (
    .setIdx  (setIdx),
    .isLeader(leaderSet)
  );

  duel_ctrl u_ctrl (
    .lookupValid(lookupValid),
    .isLeader   (leaderSet),
    .mainHit    (mainHit),
    .auxHit     (auxHit),
    .scoreMsb   (ctrVal[CTR_W-1]),
    .cmd        (cmd),
    .polSel     (polSel)
  );

  duel_score_dp #(.CTR_W(CTR_W), .COST_W(COST_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .amount(missCost),
    .score (ctrVal)
  );
endmodule

// File: rtl/duel_checker.sv
module duel_checker #(
  parameter int CTR_W  = 10,
  parameter int COST_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic              mainHit,
  input logic              auxHit,
  input logic [COST_W-1:0] missCost,
  input logic              polSel,
  input logic              leaderSet,
  input logic [CTR_W-1:0]  ctrVal
);
  logic costWin;
  logic lruWin;
  assign costWin = lookupValid && leaderSet && mainHit && !auxHit;
  assign lruWin  = lookupValid && leaderSet && !mainHit && auxHit;

  p_leader_cost_r3: assert property (@(posedge clk) disable iff (!rstN)
    leaderSet |-> polSel);

  p_tie_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && leaderSet && (mainHit == auxHit)) |=> $stable(ctrVal));

  p_no_rise_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    costWin |=> (ctrVal >= $past(ctrVal)));

  p_no_fall_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    lruWin |=> (ctrVal <= $past(ctrVal)));

  p_top_clamp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (costWin && (({1'b0, ctrVal} + (CTR_W+1)'(missCost)) > (CTR_W+1)'({CTR_W{1'b1}})))
    |=> (ctrVal == {CTR_W{1'b1}}));

  p_floor_clamp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lruWin && ((CTR_W)'(missCost) > ctrVal)) |=> (ctrVal == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(lookupValid && leaderSet) |=> $stable(ctrVal));
endmodule

bind policy_duel_sel duel_checker #(.CTR_W(CTR_W), .COST_W(COST_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupValid(lookupValid),
  .mainHit    (mainHit),
  .auxHit     (auxHit),
  .missCost   (missCost),
  .polSel     (polSel),
  .leaderSet  (leaderSet),
  .ctrVal     (ctrVal)
);

// File: tb/test_policy_duel_sel.sv
module test_policy_duel_sel;
  localparam int SET_W  = 6;
  localparam int LEAD_W = 3;
  localparam int CTR_W  = 6;
  localparam int COST_W = 3;
  localparam int MAXV   = (1 << CTR_W) - 1;
  localparam int MIDV   = 1 << (CTR_W - 1);
  localparam int FOLLOW = 1;   // 6'b000001 : low 001 vs high 000, a follower
  localparam int LEADA  = 9;   // 6'b001001 : leader
  localparam int LEADB  = 54;  // 6'b110110 : leader

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lookupValid = 1'b0;
  logic [SET_W-1:0]  setIdx = '0;
  logic              mainHit = 1'b0;
  logic              auxHit = 1'b0;
  logic [COST_W-1:0] missCost = '0;
  logic              polSel;
  logic              leaderSet;

  int nChecks = 0;
  int nFails  = 0;
  int model   = MIDV;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  policy_duel_sel #(.SET_W(SET_W), .LEAD_W(LEAD_W), .CTR_W(CTR_W), .COST_W(COST_W))
    i_policy_duel_sel (
      .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .setIdx(setIdx),
      .mainHit(mainHit), .auxHit(auxHit), .missCost(missCost),
      .polSel(polSel), .leaderSet(leaderSet));

  function automatic bit isLead(input int idx);
    return (idx % (1 << LEAD_W)) == (idx >> (SET_W - LEAD_W));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // Apply one lookup, update the model, then read the follower select.
  task automatic access(input int idx, input bit v, input bit mh, input bit ah,
                        input int cost, input string req);
    @(negedge clk);
    lookupValid = v; setIdx = SET_W'(idx); mainHit = mh; auxHit = ah;
    missCost = COST_W'(cost);
    if (v && isLead(idx)) begin
      if (mh && !ah)      model = (model + cost > MAXV) ? MAXV : model + cost;
      else if (!mh && ah) model = (model - cost < 0) ? 0 : model - cost;
    end
    @(negedge clk);
    lookupValid = 1'b0; setIdx = SET_W'(FOLLOW);
    #1 check(req, int'(polSel), (model >= MIDV) ? 1 : 0);
  endtask

  task automatic sweepSets(input string req);
    for (int i = 0; i < (1 << SET_W); i++) begin
      setIdx = SET_W'(i);
      #1;
      check({req, " R2 leader flag"}, int'(leaderSet), int'(isLead(i)));
      if (isLead(i)) check({req, " R3 leader on cost-aware"}, int'(polSel), 1);
      else check({req, " R4 follower follows msb"}, int'(polSel), (model >= MIDV) ? 1 : 0);
    end
    setIdx = SET_W'(FOLLOW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    setIdx = SET_W'(FOLLOW);
    #1 check("R1 reset midpoint", int'(polSel), 1);
    sweepSets("mid");

    // R5 R6 R7: every hit pairing with every cost, net zero per cost.
    for (int c = 0; c < (1 << COST_W); c++) begin
      access(LEADA, 1, 0, 0, c, "R5 both miss");
      access(LEADA, 1, 1, 1, c, "R5 both hit");
      access(LEADA, 1, 0, 1, c, "R7 lru wins");
      access(LEADA, 1, 1, 0, c, "R6 cost wins");
    end
    // Step just under the midpoint and back: msb must toggle.
    access(LEADB, 1, 0, 1, 1, "R7 drop by one");
    access(LEADB, 1, 1, 0, 1, "R6 rise by one");

    // R9: drive to the floor, then overshoot downward.
    for (int k = 0; k < 12; k++) access(LEADA, 1, 0, 1, 7, "R9 floor clamp");
    sweepSets("floor");
    // From a clamped 0, +28 keeps msb low, +4 more reaches the midpoint.
    for (int k = 0; k < 4; k++) access(LEADB, 1, 1, 0, 7, "R9 climb from floor");
    access(LEADB, 1, 1, 0, 3, "R9 below mid");
    access(LEADB, 1, 1, 0, 1, "R9 reach mid");

    // R8: drive to the top, then a drop of 31 must land at 32.
    for (int k = 0; k < 12; k++) access(LEADA, 1, 1, 0, 7, "R8 top clamp");
    sweepSets("top");
    for (int k = 0; k < 4; k++) access(LEADA, 1, 0, 1, 7, "R8 drop from top");
    access(LEADA, 1, 0, 1, 3, "R8 at mid");
    access(LEADA, 1, 0, 1, 1, "R8 below mid");
    access(LEADA, 1, 1, 0, 1, "R8 back to mid");

    // R10: follower lookups and invalid leader lookups must not move it.
    for (int c = 1; c < (1 << COST_W); c++) begin
      access(FOLLOW, 1, 0, 1, c, "R10 follower lookup");
      access(FOLLOW + 2, 1, 0, 1, c, "R10 follower lookup");
      access(LEADA, 0, 0, 1, c, "R10 invalid leader");
    end
    access(LEADA, 1, 0, 1, 1, "R10 counter still at mid");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule